// File: doc/BRIEF.md
# Pair Compare-Exchange Unit

This execution unit performs an atomic compare-and-exchange of a register pair against one memory location. The caller presents an expected value split into a high and a low half, a replacement value split the same way, a byte address and a two-bit operand-size mode, and pulses `start`. The unit reads memory through a simple request/response port and compares the full-width value with the expected pair. On a match it writes the replacement pair back. On a mismatch it returns the memory contents as the new expected pair. Both the read and any write are issued with a lock output raised, so the surrounding fabric can keep the pair indivisible.

The mode selects between two widths. The narrow form uses 32-bit halves and a 64-bit memory operand. The wide form uses 64-bit halves and a 128-bit memory operand, and it requires 16-byte alignment. A misaligned wide request is rejected with a general-protection fault before any memory traffic. A faulted operation changes neither memory, nor the returned pair, nor the zero flag.

Top module: `pair_cas_unit`

## Requirements
- R1: The comparison covers the whole operand: a difference in any single bit of either half gives a mismatch (zf = 0).
- R2: On a match the unit writes the replacement pair to the address, drives zf = 1 and returns the expected pair unchanged on `res_hi`/`res_lo`.
- R3: On a mismatch the unit issues no write, drives zf = 0 and returns the memory value: high half on `res_hi`, low half on `res_lo`.
- R4: Modes 2'b00 and 2'b01 select the narrow form. The access has `mem_req_wide` = 0 and only `mem_rsp_data[63:0]` is used, with the high half in bits [63:32]. The write data is {new_hi[31:0], new_lo[31:0]} in bits [63:0], with bits [127:64] zero.
- R5: In the narrow form, bits [63:32] of every input half are ignored, and bits [63:32] of `res_hi` and `res_lo` are driven to zero.
- R6: Modes 2'b10 and 2'b11 select the wide form. The access has `mem_req_wide` = 1 and the 128-bit data is {hi, lo}, with hi in bits [127:64].
- R7: In the wide form, an address with any of bits [3:0] set raises `gp_fault` with `done`. No memory request is made, memory stays as it was, zf keeps its previous value and `res_hi`/`res_lo` return the expected pair.
- R8: The narrow form never faults, whatever the address alignment.
- R9: `mem_lock` is high for every memory request. It rises with the read request and stays high through the write response on a match, or through the compare on a mismatch. It is low while `done` is high.
- R10: A `start` pulse while `busy` is high is ignored; the running operation completes with its own operands.
- R11: `done` is a one-cycle pulse. `zf`, `gp_fault`, `res_hi` and `res_lo` are valid with it and hold until the next operation finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 2 | Operand size: 00/01 narrow, 10/11 wide |
| addr | input | ADDR_W | Byte address of the memory operand |
| cmp_hi | input | HALF_W | Expected value, high half |
| cmp_lo | input | HALF_W | Expected value, low half |
| new_hi | input | HALF_W | Replacement value, high half |
| new_lo | input | HALF_W | Replacement value, low half |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| zf | output | 1 | Zero flag: 1 on match |
| gp_fault | output | 1 | Alignment fault of the last operation |
| res_hi | output | HALF_W | Updated expected value, high half |
| res_lo | output | HALF_W | Updated expected value, low half |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_wide | output | 1 | Request is 128-bit (else 64-bit) |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | 2*HALF_W | Write data |
| mem_rsp_valid | input | 1 | Response valid (read data or write acknowledge) |
| mem_rsp_data | input | 2*HALF_W | Read data |
| mem_lock | output | 1 | Indivisible-access lock |

## Verification
The bench builds the unit with its defaults: HALF_W = 64, giving both the full 128-bit form and the narrow form, and ADDR_W = 32. The 64-bit halves let the bench load garbage into the upper 32 bits of the narrow inputs and have its memory model return garbage above bit 63. This exercises the masking on the input side and on the read path. A memory model that stalls `mem_req_ready` on alternate operations keeps the lock window and the ignored `start` under test while requests are held off.

// File: rtl/pcas_pkg.sv
package pcas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_COMPARE,
    ST_WRITE,
    ST_DONE
  } pcas_state_e;

  typedef enum logic [1:0] {
    MODE_W16  = 2'b00,
    MODE_W32  = 2'b01,
    MODE_W64  = 2'b10,
    MODE_W64X = 2'b11
  } pcas_mode_e;

  // Wide (128-bit operand) form selected by the size mode
  function automatic logic mode_is_wide(input logic [1:0] m);
    logic w;
    case (m)
      MODE_W64, MODE_W64X: w = 1'b1;
      default:             w = 1'b0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pcas_align_chk.sv
module pcas_align_chk #(
  parameter int LG2 = 4
) (
  input  logic           wide,
  input  logic [LG2-1:0] addr_lo,
  output logic           fault
);
  // Only the wide form carries an alignment requirement
  always_comb fault = wide && (addr_lo != '0);
endmodule

// File: rtl/pcas_pack.sv
module pcas_pack #(
  parameter int HALF_W = 64,
  parameter int NARROW_W = 32
) (
  input  logic                wide,
  input  logic [HALF_W-1:0]   hi,
  input  logic [HALF_W-1:0]   lo,
  output logic [2*HALF_W-1:0] pair
);
  always_comb begin
    pair = '0;
    if (wide) pair = {hi, lo};
    else      pair[2*NARROW_W-1:0] = {hi[NARROW_W-1:0], lo[NARROW_W-1:0]};
  end
endmodule

// File: rtl/pcas_unpack.sv
module pcas_unpack #(
  parameter int HALF_W = 64,
  parameter int NARROW_W = 32
) (
  input  logic                wide,
  input  logic [2*HALF_W-1:0] pair,
  output logic [HALF_W-1:0]   hi,
  output logic [HALF_W-1:0]   lo
);
  always_comb begin
    hi = '0;
    lo = '0;
    if (wide) begin
      hi = pair[2*HALF_W-1:HALF_W];
      lo = pair[HALF_W-1:0];
    end else begin
      hi[NARROW_W-1:0] = pair[2*NARROW_W-1:NARROW_W];
      lo[NARROW_W-1:0] = pair[NARROW_W-1:0];
    end
  end
endmodule

// File: rtl/pcas_ctrl.sv
module pcas_ctrl
  import pcas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fault_in,
  input  logic match,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic req_we,
  output logic lock,
  output logic busy,
  output logic done,
  output logic load_ops,
  output logic load_rd,
  output logic end_fault,
  output logic end_match,
  output logic end_miss
);

  pcas_state_e state_q, state_d;
  logic        issued_q, issued_d;

  // Control strobes derived from the current state
  always_comb begin
    busy      = (state_q != ST_IDLE);
    done      = (state_q == ST_DONE);
    lock      = (state_q == ST_READ) || (state_q == ST_COMPARE) ||
                (state_q == ST_WRITE);
    req_we    = (state_q == ST_WRITE);
    req_valid = ((state_q == ST_READ) || (state_q == ST_WRITE)) && !issued_q;
    load_ops  = (state_q == ST_IDLE) && start;
    end_fault = load_ops && fault_in;
    load_rd   = (state_q == ST_READ) && issued_q && rsp_valid;
    end_miss  = (state_q == ST_COMPARE) && !match;
    end_match = (state_q == ST_WRITE) && issued_q && rsp_valid;
  end

  // Next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (load_ops) state_d = fault_in ? ST_DONE : ST_READ;
      ST_READ:    if (load_rd) state_d = ST_COMPARE;
      ST_COMPARE: state_d = match ? ST_WRITE : ST_DONE;
      ST_WRITE:   if (end_match) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    issued_d = issued_q | (req_valid & req_ready);
    if (state_d != state_q) issued_d = 1'b0;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
    end
  end

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_request_locked: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> lock);

  a_r9_unlock_into_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> done);

  a_r3_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    end_miss |=> (done && !req_valid));

  a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !load_ops);

endmodule

// File: rtl/pair_cas_unit.sv
module pair_cas_unit
  import pcas_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [HALF_W-1:0]   cmp_hi,
  input  logic [HALF_W-1:0]   cmp_lo,
  input  logic [HALF_W-1:0]   new_hi,
  input  logic [HALF_W-1:0]   new_lo,
  output logic                busy,
  output logic                done,
  output logic                zf,
  output logic                gp_fault,
  output logic [HALF_W-1:0]   res_hi,
  output logic [HALF_W-1:0]   res_lo,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_we,
  output logic                mem_req_wide,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [2*HALF_W-1:0] mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [2*HALF_W-1:0] mem_rsp_data,
  output logic                mem_lock
);

  localparam int NARROW_W = HALF_W / 2;
  localparam int PAIR_W   = 2 * HALF_W;
  localparam int ALIGN_LG = $clog2(PAIR_W / 8);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic in_wide, fault_now;
  logic load_ops, load_rd, end_fault, end_match, end_miss, match;

  assign in_wide = mode_is_wide(mode);

  pcas_align_chk #(.LG2(ALIGN_LG)) u_align (
    .wide    (in_wide),
    .addr_lo (addr[ALIGN_LG-1:0]),
    .fault   (fault_now)
  );

  // Pack expected and replacement pairs with the same width rule
  logic [HALF_W-1:0] pk_hi [2];
  logic [HALF_W-1:0] pk_lo [2];
  logic [PAIR_W-1:0] pk_out [2];
  assign pk_hi[0] = cmp_hi;
  assign pk_lo[0] = cmp_lo;
  assign pk_hi[1] = new_hi;
  assign pk_lo[1] = new_lo;

  for (genvar g = 0; g < 2; g++) begin : g_pack
    pcas_pack #(.HALF_W(HALF_W), .NARROW_W(NARROW_W)) u_pack (
      .wide (in_wide),
      .hi   (pk_hi[g]),
      .lo   (pk_lo[g]),
      .pair (pk_out[g])
    );
  end

  // Operand registers
  logic              wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAIR_W-1:0] cmp_q, new_q, rd_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wide_q <= 1'b0;
      addr_q <= '0;
      cmp_q  <= '0;
      new_q  <= '0;
    end else if (load_ops) begin
      wide_q <= in_wide;
      addr_q <= addr;
      cmp_q  <= pk_out[0];
      new_q  <= pk_out[1];
    end
  end

  // Read capture, narrowed to the operand width
  logic [PAIR_W-1:0] rd_d;
  always_comb begin
    rd_d = mem_rsp_data;
    if (!wide_q) rd_d[PAIR_W-1:2*NARROW_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     rd_q <= '0;
    else if (load_rd) rd_q <= rd_d;
  end

  assign match = (cmp_q == rd_q);

  pcas_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .fault_in  (fault_now),
    .match     (match),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .req_valid (mem_req_valid),
    .req_we    (mem_req_we),
    .lock      (mem_lock),
    .busy      (busy),
    .done      (done),
    .load_ops  (load_ops),
    .load_rd   (load_rd),
    .end_fault (end_fault),
    .end_match (end_match),
    .end_miss  (end_miss)
  );

  // Result source: input pair on fault, memory on miss, expected on match
  logic [PAIR_W-1:0] res_src;
  logic              res_wide;
  logic [HALF_W-1:0] res_hi_d, res_lo_d;
  logic              res_en;

  always_comb begin
    res_en   = end_fault | end_match | end_miss;
    res_src  = cmp_q;
    res_wide = wide_q;
    if (end_fault) begin
      res_src  = pk_out[0];
      res_wide = in_wide;
    end else if (end_miss) begin
      res_src  = rd_q;
    end
  end

  pcas_unpack #(.HALF_W(HALF_W), .NARROW_W(NARROW_W)) u_unpack (
    .wide (res_wide),
    .pair (res_src),
    .hi   (res_hi_d),
    .lo   (res_lo_d)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_hi   <= '0;
      res_lo   <= '0;
      zf       <= 1'b0;
      gp_fault <= 1'b0;
    end else if (res_en) begin
      res_hi   <= res_hi_d;
      res_lo   <= res_lo_d;
      gp_fault <= end_fault;
      if (!end_fault) zf <= end_match;
    end
  end

  assign mem_req_addr  = addr_q;
  assign mem_req_wide  = wide_q;
  assign mem_req_wdata = new_q;

  a_r2_write_only_on_match: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req_valid && mem_req_we) |-> (cmp_q == rd_q));

  a_r7_fault_without_access: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && gp_fault) |-> !$past(mem_lock));

  a_r8_narrow_never_faults: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && gp_fault) |-> wide_q);

  a_r6_wide_access_aligned: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req_valid && mem_req_wide) |-> (mem_req_addr[ALIGN_LG-1:0] == '0));

  a_r4_narrow_wdata_upper_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req_valid && !mem_req_wide) |-> (mem_req_wdata[PAIR_W-1:2*NARROW_W] == '0));

  a_r5_narrow_result_upper_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !wide_q) |-> (res_hi[HALF_W-1:NARROW_W] == '0 && res_lo[HALF_W-1:NARROW_W] == '0));

  a_r11_results_stable_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && !start) |=> ($stable(zf) && $stable(res_hi) && $stable(res_lo)));

endmodule

// File: tb/pair_cas_unit_test.sv
`timescale 1ns/1ps
module pair_cas_unit_test;

  localparam int HW = 64;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [HW-1:0] cmp_hi = '0, cmp_lo = '0, new_hi = '0, new_lo = '0;
  logic          busy, done, zf, gp_fault;
  logic [HW-1:0] res_hi, res_lo;
  logic          mem_req_valid, mem_req_we, mem_req_wide, mem_lock;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic [127:0]  mem_req_wdata;
  logic          mem_rsp_valid;
  logic [127:0]  mem_rsp_data;

  always #2 clk = ~clk;

  pair_cas_unit #(.HALF_W(HW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr(addr),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .new_hi(new_hi), .new_lo(new_lo),
    .busy(busy), .done(done), .zf(zf), .gp_fault(gp_fault),
    .res_hi(res_hi), .res_lo(res_lo),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_wide(mem_req_wide),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_lock(mem_lock)
  );

  // Memory model: 64-bit slots indexed by address bits [7:3]
  logic [63:0]  mem [0:31];
  logic         stall = 1'b0;
  logic         pl_we = 1'b0;
  logic [4:0]   pl_idx = '0;
  logic [63:0]  pl_val = '0;
  int           n_rd, n_wr, lock_viol;
  logic         last_wide;
  logic [127:0] last_wdata;
  logic [4:0]   mi, mi1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      n_rd <= 0; n_wr <= 0; lock_viol <= 0;
      last_wide <= 1'b0; last_wdata <= '0;
    end else begin
      mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
      mem_rsp_valid <= 1'b0;
      if (pl_we) mem[pl_idx] <= pl_val;
      if ((mem_req_valid && !mem_lock) || (done && mem_lock)) lock_viol <= lock_viol + 1;
      if (mem_req_valid && mem_req_ready) begin
        mi  = mem_req_addr[7:3];
        mi1 = mi + 5'd1;
        mem_rsp_valid <= 1'b1;
        last_wide     <= mem_req_wide;
        if (mem_req_we) begin
          n_wr <= n_wr + 1;
          last_wdata <= mem_req_wdata;
          mem[mi] <= mem_req_wdata[63:0];
          if (mem_req_wide) mem[mi1] <= mem_req_wdata[127:64];
          mem_rsp_data <= '0;
        end else begin
          n_rd <= n_rd + 1;
          mem_rsp_data <= mem_req_wide ? {mem[mi1], mem[mi]}
                                       : {64'hDEAD_BEEF_DEAD_BEEF, mem[mi]};
        end
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [4:0] idx, input logic [63:0] val);
    @(negedge clk);
    pl_we = 1'b1; pl_idx = idx; pl_val = val;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic launch(input logic [1:0] m, input logic [7:0] a,
                        input logic [63:0] ch, input logic [63:0] cl,
                        input logic [63:0] nh, input logic [63:0] nl);
    @(negedge clk);
    mode = m; addr = {24'h0, a};
    cmp_hi = ch; cmp_lo = cl; new_hi = nh; new_lo = nl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k;
    k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL %s actual=no-done expected=done", tag);
    end
  endtask

  typedef struct packed {
    logic [1:0]   mode;
    logic [7:0]   addr;
    logic [63:0]  ch;
    logic [63:0]  cl;
    logic [63:0]  nh;
    logic [63:0]  nl;
    logic [127:0] mem;
    logic         ezf;
    logic         eflt;
  } vec_t;

  // Fault rows expect the zf left by the row before them
  localparam vec_t VECS [0:8] = '{
    '{2'b10, 8'h20, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
      64'hAAAA_0000_BBBB_1111, 64'hCCCC_2222_DDDD_3333,
      {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}, 1'b1, 1'b0},
    '{2'b10, 8'h30, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222,
      64'h4444_4444_4444_4444, 64'h5555_5555_5555_5555,
      {64'h1111_1111_1111_1111, 64'h2222_2222_2222_2223}, 1'b0, 1'b0},
    '{2'b01, 8'h40, 64'hFFFF_FFFF_1111_2222, 64'hEEEE_EEEE_3333_4444,
      64'h9999_9999_5555_6666, 64'h8888_8888_7777_8888,
      {64'hC0FF_EE00_C0FF_EE00, 64'h1111_2222_3333_4444}, 1'b1, 1'b0},
    '{2'b00, 8'h4B, 64'h0000_0000_0000_0001, 64'h0000_0000_ABCD_EF01,
      64'h0000_0000_0000_0007, 64'h0000_0000_0000_0008,
      {64'h5A5A_5A5A_5A5A_5A5A, 64'h0000_0002_ABCD_EF01}, 1'b0, 1'b0},
    '{2'b10, 8'h58, 64'h0000_0000_0000_00AA, 64'h0000_0000_0000_00BB,
      64'h0000_0000_0000_00CC, 64'h0000_0000_0000_00DD,
      {64'h0000_0000_0000_00AA, 64'h0000_0000_0000_00BB}, 1'b0, 1'b1},
    '{2'b11, 8'h60, 64'h7777_7777_7777_7777, 64'h3333_3333_3333_3333,
      64'h1010_1010_1010_1010, 64'h2020_2020_2020_2020,
      {64'h7777_7777_7777_7776, 64'h3333_3333_3333_3333}, 1'b0, 1'b0},
    '{2'b00, 8'h77, 64'h1234_5678_0000_AAAA, 64'h0BAD_F00D_0000_BBBB,
      64'h0000_0000_0000_1234, 64'hFFFF_0000_0000_5678,
      {64'h6666_6666_6666_6666, 64'h0000_AAAA_0000_BBBB}, 1'b1, 1'b0},
    '{2'b10, 8'h84, 64'h0000_0000_0000_0011, 64'h0000_0000_0000_0022,
      64'h0000_0000_0000_0033, 64'h0000_0000_0000_0044,
      {64'h0000_0000_0000_0011, 64'h0000_0000_0000_0022}, 1'b1, 1'b1},
    '{2'b11, 8'hF0, 64'hABAB_ABAB_ABAB_ABAB, 64'hCDCD_CDCD_CDCD_CDCD,
      64'hEFEF_EFEF_EFEF_EFEF, 64'h0101_0101_0101_0101,
      {64'hABAB_ABAB_ABAB_ABAB, 64'hCDCD_CDCD_CDCD_CDCD}, 1'b1, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state (R11)
    chk("R11 reset done", {127'h0, done}, 128'h0);
    chk("R11 reset zf/fault", {126'h0, zf, gp_fault}, 128'h0);
    chk("R9 reset lock/req", {126'h0, mem_lock, mem_req_valid}, 128'h0);
    chk("R10 reset busy", {127'h0, busy}, 128'h0);

    for (int i = 0; i < 9; i++) begin
      vec_t v;
      logic w, hit;
      logic [4:0] ix;
      logic [63:0] mh, ml, eh, el, es0, es1;
      int rd0, wr0;
      v   = VECS[i];
      w   = v.mode[1];
      ix  = v.addr[7:3];
      hit = v.ezf && !v.eflt;
      preload(ix, v.mem[63:0]);
      preload(ix + 5'd1, v.mem[127:64]);
      stall = (i % 2 == 1);
      rd0 = n_rd; wr0 = n_wr;
      launch(v.mode, v.addr, v.ch, v.cl, v.nh, v.nl);
      wait_done("R11 completion");

      mh = w ? v.ch : {32'h0, v.ch[31:0]};
      ml = w ? v.cl : {32'h0, v.cl[31:0]};
      if (v.eflt || hit) begin
        eh = mh; el = ml;
      end else begin
        eh = w ? v.mem[127:64] : {32'h0, v.mem[63:32]};
        el = w ? v.mem[63:0]   : {32'h0, v.mem[31:0]};
      end

      if (v.eflt)     chk("R7 zf held on fault", {127'h0, zf}, {127'h0, v.ezf});
      else if (hit)   chk("R2 zf on match", {127'h0, zf}, {127'h0, v.ezf});
      else            chk("R3 R1 zf on mismatch", {127'h0, zf}, {127'h0, v.ezf});
      if (w) chk("R7 fault flag", {127'h0, gp_fault}, {127'h0, v.eflt});
      else   chk("R8 narrow no fault", {127'h0, gp_fault}, 128'h0);
      if (w) chk("R2 R3 R7 result pair", {res_hi, res_lo}, {eh, el});
      else   chk("R5 narrow result pair", {res_hi, res_lo}, {eh, el});

      @(negedge clk);
      chk("R11 done pulse ends", {127'h0, done}, 128'h0);
      chk("R11 result held", {zf, res_hi, res_lo}, {(v.eflt ? v.ezf : v.ezf), eh, el});

      es0 = v.mem[63:0];
      es1 = v.mem[127:64];
      if (hit) begin
        es0 = w ? v.nl : {v.nh[31:0], v.nl[31:0]};
        if (w) es1 = v.nh;
      end
      if (hit) chk("R2 R4 memory after match", {mem[ix + 5'd1], mem[ix]}, {es1, es0});
      else     chk("R3 R7 memory unchanged", {mem[ix + 5'd1], mem[ix]}, {es1, es0});
      chk("R7 R3 read/write counts", {64'(n_rd - rd0), 64'(n_wr - wr0)},
          {64'(v.eflt ? 0 : 1), 64'(hit ? 1 : 0)});
      if (!v.eflt) begin
        if (w) chk("R6 wide access", {127'h0, last_wide}, 128'h1);
        else   chk("R4 narrow access", {127'h0, last_wide}, 128'h0);
      end
      if (hit && !w) chk("R4 narrow wdata upper zero", {64'h0, last_wdata[127:64]}, 128'h0);
    end

    // R10: a second start while busy is dropped
    begin
      int rd0, wr0;
      preload(5'd20, 64'h0000_0000_0000_0B0B);
      preload(5'd21, 64'h0000_0000_0000_0A0A);
      stall = 1'b1;
      rd0 = n_rd; wr0 = n_wr;
      launch(2'b10, 8'hA0, 64'h0A0A, 64'h0B0B, 64'h1C1C, 64'h1D1D);
      @(negedge clk);
      mode = 2'b10; addr = 32'h0000_00C0;
      cmp_hi = 64'h9; cmp_lo = 64'h9; new_hi = 64'h7; new_lo = 64'h7;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R10 completion");
      chk("R10 first op result", {127'h0, zf}, 128'h1);
      chk("R10 first op pair", {res_hi, res_lo}, {64'h0A0A, 64'h0B0B});
      repeat (10) @(negedge clk);
      chk("R10 memory from first op", {mem[21], mem[20]}, {64'h1C1C, 64'h1D1D});
      chk("R10 single access pair", {64'(n_rd - rd0), 64'(n_wr - wr0)}, {64'd1, 64'd1});
      chk("R10 idle after", {127'h0, busy}, 128'h0);
    end

    chk("R9 lock window violations", 128'(lock_viol), 128'h0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule